// File: doc/BRIEF.md
# Posted-Write Register Domain Synchronizer

This block connects a register interface running on a fast bus clock to a timer core that runs on a slower, unrelated functional clock. Ten core registers are mirrored across the boundary. Each one has its own toggle handshake, built from two-flop synchronizers in both directions, and its own bit in a write-pending status word. Three registers exist only in the bus domain: the pending status, an interface control word and a wakeup enable word. These answer at once.

Bit 2 of the interface control word selects how writes complete. In stalling mode a write to a mirrored register holds the grant low until the functional domain has taken the value. In posted mode the write is granted in its first cycle, and the pending bit tracks the transfer until the acknowledge returns. In both modes, any access to a register whose pending bit is set waits for that bit to clear.

The functional domain holds a register file. One entry is a free-running counter that advances once per functional clock while bit 0 of the control entry is set. A counter read captures the live value in the functional domain and carries it back over its own handshake, so the bus never sees a torn value.

Top module: `pwsync_bridge`

## Requirements
- R1: After reset, every pending bit is 0, the interface control and wakeup words read 0, and every functional register holds 0.
- R2: Reading address 10 returns the pending word. Bit i belongs to the mirrored register at address i (0 control, 1 counter, 2 load, 3 trigger, 4 match, 5 positive increment, 6 negative increment, 7 tick count, 8 overflow mask, 9 overflow wrap). Bits 10 and up read 0.
- R3: With bit 2 of the interface control word (address 11) clear, a write to addresses 0..9 keeps gnt_o low for at least two cycles. When the grant comes, the functional register already holds the new value and the pending bit is clear.
- R4: With bit 2 set, a write to a mirrored register whose pending bit is clear is granted in its first request cycle. Its pending bit then reads 1, later clears without further bus activity, and the functional register then holds the value.
- R5: A read or write to a mirrored register whose pending bit is set is not granted until that bit clears.
- R6: Transfers to different mirrored registers may be in flight together, so more than one pending bit can be set at once.
- R7: The wakeup word (address 12), the interface control word and the pending word are granted in the first request cycle and never set a pending bit. Writes to the pending word are ignored.
- R8: A counter read (address 1) returns the value captured in the functional domain. Reads of the other mirrored addresses return the last value written.
- R9: The counter advances by one per functional clock while control bit 0 is set in the functional domain. After a stalling write that clears the bit completes, successive counter reads return the same value.
- R10: Addresses 13 to 15 are granted in the first cycle, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| fclk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| req_i | input | 1 | Access request, held until granted |
| we_i | input | 1 | 1 write, 0 read |
| addr_i | input | 4 | Word address |
| wdata_i | input | DW | Write data |
| gnt_o | output | 1 | Access completes at this clock edge |
| rdata_o | output | DW | Read data, valid while gnt_o is high |
| core_regs_o | output | 10*DW | Functional register file, entry i at [i*DW +: DW] |

## Verification
The hardest case to reach is an access that meets its own register's transfer while that transfer is still in flight. This has to happen within the few functional clocks of a round trip. The bench reaches it by issuing posted writes back to back: a second write to the same register, a read right after a posted write, and a burst over eight registers followed at once by a read of the pending word. With the functional clock set well below the bus clock, every round trip spans several bus cycles, so these collisions happen on every run.

// File: rtl/pwsync_pkg.sv
package pwsync_pkg;
  localparam int NSYNC  = 10;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_CNT  = 4'd1;
  localparam logic [ADDR_W-1:0] A_PEND = 4'd10;
  localparam logic [ADDR_W-1:0] A_IFC  = 4'd11;
  localparam logic [ADDR_W-1:0] A_WAKE = 4'd12;

  localparam int POSTED_BIT = 2;
  localparam int RUN_BIT    = 0;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WWAIT = 2'd1,
    ST_RWAIT = 2'd2
  } bus_st_e;
endpackage

// File: rtl/pwsync_sync2.sv
module pwsync_sync2 #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pwsync_wr_chan.sv
module pwsync_wr_chan #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          fclk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  output logic          pend_o,
  output logic [DW-1:0] shadow_o,
  output logic          fupd_o
);
  logic          req_q, ack_s, req_s, req_d;
  logic [DW-1:0] shadow_q;

  // bus side: shadow holds the value until the round trip finishes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q    <= 1'b0;
      shadow_q <= '0;
    end else if (load_i) begin
      req_q    <= ~req_q;
      shadow_q <= data_i;
    end
  end

  pwsync_sync2 #(.W(1)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_d),
    .q_o   (ack_s)
  );

  assign pend_o   = req_q ^ ack_s;
  assign shadow_o = shadow_q;

  // functional side
  pwsync_sync2 #(.W(1)) u_req_sync (
    .clk_i (fclk_i),
    .rst_ni(rst_ni),
    .d_i   (req_q),
    .q_o   (req_s)
  );

  always_ff @(posedge fclk_i or negedge rst_ni) begin
    if (!rst_ni) req_d <= 1'b0;
    else         req_d <= req_s;
  end

  assign fupd_o = req_s ^ req_d;

  a_r5_no_load_while_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !pend_o);
  a_r4_pend_from_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o) |-> $past(load_i));
  a_r4_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !load_i) |=> $stable(shadow_q));
endmodule

// File: rtl/pwsync_rd_snap.sv
module pwsync_rd_snap #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          fclk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] fval_i,
  output logic          done_o,
  output logic [DW-1:0] snap_o
);
  logic          req_q, ack_s, req_s, req_d;
  logic [DW-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      req_q <= 1'b0;
    else if (start_i) req_q <= ~req_q;
  end

  pwsync_sync2 #(.W(1)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_d),
    .q_o   (ack_s)
  );

  assign done_o = (req_q == ack_s);

  pwsync_sync2 #(.W(1)) u_req_sync (
    .clk_i (fclk_i),
    .rst_ni(rst_ni),
    .d_i   (req_q),
    .q_o   (req_s)
  );

  always_ff @(posedge fclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_d  <= 1'b0;
      snap_q <= '0;
    end else begin
      req_d <= req_s;
      if (req_s != req_d) snap_q <= fval_i;
    end
  end

  assign snap_o = snap_q;

  a_r8_single_snap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> done_o);
  a_r8_done_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);
endmodule

// File: rtl/pwsync_func_core.sv
module pwsync_func_core #(
  parameter int DW       = 32,
  parameter int NREG     = 10,
  parameter int CNT_IDX  = 1,
  parameter int CTRL_IDX = 0,
  parameter int RUN_BIT  = 0
) (
  input  logic                     fclk_i,
  input  logic                     rst_ni,
  input  logic [NREG-1:0]          upd_i,
  input  logic [NREG-1:0][DW-1:0]  wdata_i,
  output logic [NREG-1:0][DW-1:0]  regs_o
);
  logic [NREG-1:0][DW-1:0] regs_q;
  logic                    run;

  assign run = regs_q[CTRL_IDX][RUN_BIT];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == CNT_IDX) begin : g_cnt
      always_ff @(posedge fclk_i or negedge rst_ni) begin
        if (!rst_ni)       regs_q[g] <= '0;
        else if (upd_i[g]) regs_q[g] <= wdata_i[g];
        else if (run)      regs_q[g] <= regs_q[g] + 1'b1;
      end
    end else begin : g_plain
      always_ff @(posedge fclk_i or negedge rst_ni) begin
        if (!rst_ni)       regs_q[g] <= '0;
        else if (upd_i[g]) regs_q[g] <= wdata_i[g];
      end
    end
  end

  assign regs_o = regs_q;

  a_r9_cnt_hold: assert property (@(posedge fclk_i) disable iff (!rst_ni)
    (!run && !upd_i[CNT_IDX]) |=> $stable(regs_q[CNT_IDX]));
  a_r9_cnt_step: assert property (@(posedge fclk_i) disable iff (!rst_ni)
    (run && !upd_i[CNT_IDX]) |=> (regs_q[CNT_IDX] == $past(regs_q[CNT_IDX]) + 1'b1));
endmodule

// File: rtl/pwsync_bridge.sv
module pwsync_bridge
  import pwsync_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                  clk_i,
  input  logic                  fclk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DW-1:0]         wdata_i,
  output logic                  gnt_o,
  output logic [DW-1:0]         rdata_o,
  output logic [NSYNC*DW-1:0]   core_regs_o
);
  bus_st_e                  st_q, st_d;
  logic [ADDR_W-1:0]        addr_q;
  logic [DW-1:0]            ifc_q, wake_q;
  logic [NSYNC-1:0]         load, pend, fupd;
  logic [NSYNC-1:0][DW-1:0] shadow, core_q;
  logic                     rd_start, snap_done;
  logic [DW-1:0]            snap;
  logic                     is_sync, pend_hit, pend_q_hit, posted;
  logic [DW-1:0]            shadow_rd;

  assign posted  = ifc_q[POSTED_BIT];
  assign is_sync = (addr_i < ADDR_W'(NSYNC));

  always_comb begin
    pend_hit   = 1'b0;
    pend_q_hit = 1'b0;
    shadow_rd  = '0;
    for (int i = 0; i < NSYNC; i++) begin
      if (addr_i == ADDR_W'(i)) begin
        pend_hit  = pend[i];
        shadow_rd = shadow[i];
      end
      if (addr_q == ADDR_W'(i)) pend_q_hit = pend[i];
    end
  end

  for (genvar g = 0; g < NSYNC; g++) begin : g_chan
    pwsync_wr_chan #(.DW(DW)) u_chan (
      .clk_i   (clk_i),
      .fclk_i  (fclk_i),
      .rst_ni  (rst_ni),
      .load_i  (load[g]),
      .data_i  (wdata_i),
      .pend_o  (pend[g]),
      .shadow_o(shadow[g]),
      .fupd_o  (fupd[g])
    );
  end

  pwsync_rd_snap #(.DW(DW)) u_snap (
    .clk_i  (clk_i),
    .fclk_i (fclk_i),
    .rst_ni (rst_ni),
    .start_i(rd_start),
    .fval_i (core_q[A_CNT]),
    .done_o (snap_done),
    .snap_o (snap)
  );

  pwsync_func_core #(
    .DW      (DW),
    .NREG    (NSYNC),
    .CNT_IDX (int'(A_CNT)),
    .CTRL_IDX(int'(A_CTRL)),
    .RUN_BIT (RUN_BIT)
  ) u_core (
    .fclk_i (fclk_i),
    .rst_ni (rst_ni),
    .upd_i  (fupd),
    .wdata_i(shadow),
    .regs_o (core_q)
  );

  assign core_regs_o = core_q;

  // access control
  always_comb begin
    st_d     = st_q;
    gnt_o    = 1'b0;
    rdata_o  = '0;
    load     = '0;
    rd_start = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_i) begin
          if (is_sync) begin
            if (!pend_hit) begin
              if (we_i) begin
                for (int i = 0; i < NSYNC; i++)
                  if (addr_i == ADDR_W'(i)) load[i] = 1'b1;
                if (posted) gnt_o = 1'b1;
                else        st_d  = ST_WWAIT;
              end else if (addr_i == A_CNT) begin
                rd_start = 1'b1;
                st_d     = ST_RWAIT;
              end else begin
                gnt_o   = 1'b1;
                rdata_o = shadow_rd;
              end
            end
          end else begin
            gnt_o = 1'b1;
            if (!we_i) begin
              if (addr_i == A_PEND)      rdata_o[NSYNC-1:0] = pend;
              else if (addr_i == A_IFC)  rdata_o = ifc_q;
              else if (addr_i == A_WAKE) rdata_o = wake_q;
            end
          end
        end
      end
      ST_WWAIT: begin
        if (!pend_q_hit) begin
          gnt_o = 1'b1;
          st_d  = ST_IDLE;
        end
      end
      ST_RWAIT: begin
        if (snap_done) begin
          gnt_o   = 1'b1;
          rdata_o = snap;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      ifc_q  <= '0;
      wake_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE) addr_q <= addr_i;
      if (st_q == ST_IDLE && req_i && we_i) begin
        if (addr_i == A_IFC)  ifc_q  <= wdata_i;
        if (addr_i == A_WAKE) wake_q <= wdata_i;
      end
    end
  end

  a_r3_np_no_early_gnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && req_i && we_i && is_sync && !posted) |-> !gnt_o);
  a_r3_np_landed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WWAIT && gnt_o) |-> ($countones(load) == 0 && !pend_q_hit));
  a_r5_no_gnt_on_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && req_i && is_sync && pend_hit) |-> (!gnt_o && $countones(load) == 0));
  a_r4_single_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load));
  a_r7_direct_gnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && req_i && !is_sync) |-> gnt_o);
  a_r8_snap_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_start |=> (st_q == ST_RWAIT));
endmodule

// File: tb/pwsync_bridge_tb.sv
module pwsync_bridge_tb;
  localparam int CLK_PERIOD  = 10;
  localparam int FCLK_PERIOD = 34;
  localparam int DW = 32;
  localparam int NS = 10;

  logic          clk = 1'b0, fclk = 1'b0, rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [3:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          gnt;
  logic [DW-1:0] rdata;
  logic [NS*DW-1:0] core_regs;

  int total = 0, bad = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(FCLK_PERIOD/2) fclk = ~fclk;

  pwsync_bridge #(.DW(DW)) u_dut (
    .clk_i      (clk),
    .fclk_i     (fclk),
    .rst_ni     (rst_n),
    .req_i      (req),
    .we_i       (we),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .gnt_o      (gnt),
    .rdata_o    (rdata),
    .core_regs_o(core_regs)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp<=%0d", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input bit w, input logic [3:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output int lat);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; lat = 0; rd = '0;
    while (1) begin
      #1;
      lat++;
      if (gnt) begin
        rd = rdata;
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    #1 req = 1'b0;
  endtask

  function automatic logic [DW-1:0] core(input int i);
    return core_regs[i*DW +: DW];
  endfunction

  function automatic logic [DW-1:0] v1(input int i);
    return (32'h1357_0000 ^ (i * 32'h0101_0100)) & ~32'h1;
  endfunction

  function automatic logic [DW-1:0] v2(input int i);
    return (32'hC0DE_0000 + i * 32'h0000_1110) & ~32'h1;
  endfunction

  task automatic wait_clear(output logic [DW-1:0] last);
    int lat;
    for (int k = 0; k < 200; k++) begin
      access(1'b0, 4'd10, '0, last, lat);
      if (last == '0) break;
    end
  endtask

  initial begin
    logic [DW-1:0] rd, c1, c2, c3, c4;
    int lat;

    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R1 reset state
    for (int i = 0; i < NS; i++) check(core(i) == '0, "R1 core reg reset", core(i), '0);
    access(1'b0, 4'd10, '0, rd, lat); check(rd == '0, "R1 pending reset", rd, '0);
    access(1'b0, 4'd11, '0, rd, lat); check(rd == '0, "R1 ifctrl reset", rd, '0);
    access(1'b0, 4'd12, '0, rd, lat); check(rd == '0, "R1 wakeup reset", rd, '0);

    // R3 stalling sweep
    for (int i = 0; i < NS; i++) begin
      access(1'b1, 4'(i), v1(i), rd, lat);
      check(lat >= 3, "R3 stall length", lat, 3);
      check(core(i) == v1(i), "R3 landed at grant", core(i), v1(i));
      access(1'b0, 4'd10, '0, rd, lat);
      check(rd == '0, "R3 pending clear", rd, '0);
    end
    // R8 readback
    for (int i = 0; i < NS; i++) begin
      access(1'b0, 4'(i), '0, rd, lat);
      check(rd == v1(i), "R8 readback", rd, v1(i));
    end

    // R7 direct registers
    access(1'b1, 4'd12, 32'h5A, rd, lat); check(lat == 1, "R7 wake write latency", lat, 1);
    access(1'b0, 4'd12, '0, rd, lat);
    check(rd == 32'h5A && lat == 1, "R7 wake read", rd, 32'h5A);
    access(1'b1, 4'd10, 32'hFFFF, rd, lat);
    access(1'b0, 4'd10, '0, rd, lat); check(rd == '0, "R7 pending write ignored", rd, '0);
    for (int i = 0; i < NS; i++) check(core(i) == v1(i), "R7 no side effect", core(i), v1(i));

    // R10 unmapped
    for (int a = 13; a < 16; a++) begin
      access(1'b1, 4'(a), 32'hDEAD_BEEF, rd, lat); check(lat == 1, "R10 write latency", lat, 1);
      access(1'b0, 4'(a), '0, rd, lat);
      check(rd == '0 && lat == 1, "R10 reads zero", rd, '0);
    end

    // R4 posted sweep, R2 bit positions
    access(1'b1, 4'd11, 32'h4, rd, lat);
    access(1'b0, 4'd11, '0, rd, lat); check(rd == 32'h4, "R7 ifctrl readback", rd, 32'h4);
    for (int i = 0; i < NS; i++) begin
      access(1'b1, 4'(i), v2(i), rd, lat);
      check(lat == 1, "R4 posted grant", lat, 1);
      access(1'b0, 4'd10, '0, rd, lat);
      check(rd == (32'h1 << i), "R2 pending bit position", rd, 32'h1 << i);
      wait_clear(rd);
      check(rd == '0, "R4 pending clears", rd, '0);
      check(core(i) == v2(i), "R4 landed", core(i), v2(i));
    end

    // R6 overlap
    for (int i = 2; i < NS; i++) access(1'b1, 4'(i), v1(i), rd, lat);
    access(1'b0, 4'd10, '0, rd, lat);
    check($countones(rd) >= 2 && rd[9] && rd[DW-1:NS] == '0, "R6 overlapping pending", rd, 32'h200);
    wait_clear(rd);
    for (int i = 2; i < NS; i++) check(core(i) == v1(i), "R6 all landed", core(i), v1(i));

    // R5 collisions
    access(1'b1, 4'd4, 32'hAAAA_0000, rd, lat);
    access(1'b1, 4'd4, 32'hBBBB_0000, rd, lat);
    check(lat > 1, "R5 write waits on pending", lat, 2);
    access(1'b0, 4'd4, '0, rd, lat);
    check(lat > 1, "R5 read waits on pending", lat, 2);
    check(rd == 32'hBBBB_0000, "R8 read after wait", rd, 32'hBBBB_0000);
    wait_clear(rd);
    check(core(4) == 32'hBBBB_0000, "R5 final value", core(4), 32'hBBBB_0000);
    access(1'b1, 4'd1, 32'h0000_0100, rd, lat);
    access(1'b0, 4'd1, '0, rd, lat);
    check(lat > 1, "R5 counter read waits", lat, 2);
    check(rd == 32'h100, "R8 counter snapshot", rd, 32'h100);

    // R9 counter run and stop
    access(1'b1, 4'd0, 32'h1, rd, lat);
    wait_clear(rd);
    access(1'b0, 4'd1, '0, c1, lat);
    repeat (20) @(posedge clk);
    access(1'b0, 4'd1, '0, c2, lat);
    check(c2 > c1 && (c2 - c1) <= 32'd20, "R9 counter advances", c2 - c1, 32'd8);
    check(c1 >= 32'h100, "R9 counter from load", c1, 32'h100);
    access(1'b1, 4'd11, 32'h0, rd, lat);
    access(1'b1, 4'd0, 32'h0, rd, lat);
    check(core(0) == '0, "R9 stop landed", core(0), '0);
    access(1'b0, 4'd1, '0, c3, lat);
    repeat (20) @(posedge clk);
    access(1'b0, 4'd1, '0, c4, lat);
    check(c3 == c4, "R9 counter stopped", c4, c3);
    check(c3 >= c2, "R9 counter monotonic", c3, c2);
    check(core(1) == c4, "R8 snapshot matches core", c4, core(1));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule